// File: doc/BRIEF.md
# Thermal Event Comparator

This block is the digital alarm stage of a module thermal sensor. Each time the converter delivers a new reading, the block compares that signed temperature word against three programmable limits: a lower bound, an upper bound and a critical trip point. It keeps one status flag per limit. Each flag sets when its limit is crossed. It clears only after the reading moves back past the limit by a programmable hysteresis margin.

From these flags the block drives an active-low alarm output. The output suits an open-drain pad, whose enable is the inverse of the output. Software selects one of three behaviours for the output:

- **Latched interrupt.** The output holds a crossing until a software clear pulse.
- **Comparator.** The output follows the flags and software cannot clear it.
- **Critical-only.** The output reacts to the critical limit alone.

A critical crossing always drives the output as a comparator, whatever the selected behaviour. Software cannot clear that alarm.

Limits and configuration are loaded through simple write strobes. The bus transport and the register address decoding sit outside this block.

Top module: `therm_event_top`

## Requirements
- R1: After reset, eventN is 1 and aboveHigh, belowLow and aboveCrit are 0. The reset limits are lower = -4096, upper = +4095 and critical = +4095 LSB. The reset configuration is all zero.
- R2: On a sample, aboveHigh sets when temp > upper, using a signed compare. It clears when temp <= upper - H, and otherwise holds. H in LSB is 0, 24, 48 or 96 for hysteresis codes 0, 1, 2 and 3 (0, 1.5, 3 and 6 °C at 0.0625 °C per LSB).
- R3: On a sample, belowLow sets when temp < lower. It clears when temp >= lower + H, and otherwise holds.
- R4: On a sample, aboveCrit sets when temp > critical. It clears when temp <= critical - H, and otherwise holds.
- R5: The three flags change only in a cycle where sampleValid is 1.
- R6: In comparator mode (mode code 1 or 3), eventN is 0 exactly when aboveCrit is set, or when windowEn is set and aboveHigh or belowLow is set. clearPulse has no effect in this mode.
- R7: In latched mode (mode code 0), a sample on which a window flag (with windowEn set) or the critical flag goes from 0 to 1 latches the alarm. clearPulse releases the alarm even while the condition persists. A new latch needs a fresh 0-to-1 transition of a flag.
- R8: While aboveCrit is set, eventN is 0 in every mode whenever the output is enabled. clearPulse cannot release it.
- R9: In critical-only mode (mode code 2), eventN is 0 exactly when aboveCrit is set.
- R10: While eventEn is 0, eventN stays 1, and the flags keep updating on samples.
- R11: A limit write with limSel 0 loads lower, 1 loads upper and 2 loads critical. limSel 3 changes nothing. The configuration word is eventEn in bit 0, windowEn in bit 1, the mode in bits 3:2 and the hysteresis code in bits 5:4.
- R12: With windowEn at 0, the window flags still update but do not assert eventN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | Strobe: sampleTemp holds a new reading |
| sampleTemp | input | 13 | Two's-complement temperature, 0.0625 °C per LSB |
| limWrEn | input | 1 | Limit write strobe |
| limSel | input | 2 | Limit select: 0 lower, 1 upper, 2 critical, 3 none |
| limWrData | input | 13 | Signed limit value to write |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrData | input | 6 | Configuration word: hysteresis[5:4], mode[3:2], windowEn[1], eventEn[0] |
| clearPulse | input | 1 | Software clear of the latched alarm |
| eventN | output | 1 | Active-low alarm; pad driven low when 0, released when 1 |
| aboveHigh | output | 1 | Status: above the upper limit |
| belowLow | output | 1 | Status: below the lower limit |
| aboveCrit | output | 1 | Status: above the critical limit |

## Verification
Every result is due one clock edge after its stimulus:

- A sample updates the flags and the latched alarm on the edge that captures sampleValid.
- A limit or configuration write takes effect on its capturing edge.
- A clear pulse releases the latch on its capturing edge.

eventN is decoded combinationally from these registers, so it settles in that same cycle.

The bench drives all inputs on the falling edge. It advances a requirement-based reference model at the rising edge and compares all four outputs shortly after that edge, so each check lands exactly one register stage after its stimulus.

// File: rtl/therm_event_pkg.sv
package therm_event_pkg;

  localparam int SEL_W      = 2;
  localparam int CFG_W      = 6;
  localparam int LIM_LOWER  = 0;
  localparam int LIM_UPPER  = 1;
  localparam int LIM_CRIT   = 2;
  localparam int NUM_LIMITS = 3;

  // Alarm output behaviour; code 3 behaves as comparator (R6)
  typedef enum logic [1:0] {
    EV_MODE_LATCH = 2'd0,
    EV_MODE_CMP   = 2'd1,
    EV_MODE_CRIT  = 2'd2,
    EV_MODE_CMP2  = 2'd3
  } evMode_e;

  // Field order fixes the write word layout (R11)
  typedef struct packed {
    logic [1:0] hyst;
    evMode_e    mode;
    logic       windowEn;
    logic       eventEn;
  } evCfg_t;

  // Comparison results the datapath hands to the control
  typedef struct packed {
    logic hiSet;
    logic hiClr;
    logic loSet;
    logic loClr;
    logic crSet;
    logic crClr;
  } cmpStrobe_t;

endpackage

// File: rtl/therm_event_regs.sv
module therm_event_regs
  import therm_event_pkg::*;
#(
  parameter int TEMP_W = 13
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     limWrEn,
  input  logic [SEL_W-1:0]         limSel,
  input  logic [TEMP_W-1:0]        limWrData,
  input  logic                     cfgWrEn,
  input  logic [CFG_W-1:0]         cfgWrData,
  output evCfg_t                   cfg,
  output logic signed [TEMP_W-1:0] lowerLim,
  output logic signed [TEMP_W-1:0] upperLim,
  output logic signed [TEMP_W-1:0] critLim
);

  localparam logic [TEMP_W-1:0] MOST_NEG = {1'b1, {(TEMP_W-1){1'b0}}};
  localparam logic [TEMP_W-1:0] MOST_POS = {1'b0, {(TEMP_W-1){1'b1}}};

  logic [TEMP_W-1:0] limQ [NUM_LIMITS];

  // One register per limit; select code 3 matches none of them (R11)
  for (genvar gi = 0; gi < NUM_LIMITS; gi++) begin : g_lim
    localparam logic [TEMP_W-1:0] RST_VAL = (gi == LIM_LOWER) ? MOST_NEG : MOST_POS;
    always_ff @(posedge clk) begin
      if (!rstN)
        limQ[gi] <= RST_VAL;
      else if (limWrEn && (limSel == SEL_W'(gi)))
        limQ[gi] <= limWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      cfg <= '0;
    else if (cfgWrEn)
      cfg <= evCfg_t'(cfgWrData);
  end

  assign lowerLim = $signed(limQ[LIM_LOWER]);
  assign upperLim = $signed(limQ[LIM_UPPER]);
  assign critLim  = $signed(limQ[LIM_CRIT]);

endmodule

// File: rtl/therm_event_datapath.sv
module therm_event_datapath
  import therm_event_pkg::*;
#(
  parameter int TEMP_W    = 13,
  parameter int FRAC_BITS = 4
) (
  input  logic signed [TEMP_W-1:0] sampleTemp,
  input  logic signed [TEMP_W-1:0] lowerLim,
  input  logic signed [TEMP_W-1:0] upperLim,
  input  logic signed [TEMP_W-1:0] critLim,
  input  logic [1:0]               hystCode,
  output cmpStrobe_t               strobes
);

  // Two guard bits so limit +/- hysteresis never wraps
  localparam int EXT_W = TEMP_W + 2;
  // 1.5 degC expressed in LSB
  localparam int HYST_BASE = 3 << (FRAC_BITS - 1);

  logic signed [EXT_W-1:0] tempX;
  logic signed [EXT_W-1:0] lowerX;
  logic signed [EXT_W-1:0] hystX;
  logic signed [EXT_W-1:0] highLimX [2];
  logic                    highSet  [2];
  logic                    highClr  [2];

  // Hysteresis codes 0..3 map to 0, 1x, 2x, 4x the base step (R2)
  always_comb begin
    unique case (hystCode)
      2'd0:    hystX = '0;
      2'd1:    hystX = EXT_W'(HYST_BASE);
      2'd2:    hystX = EXT_W'(HYST_BASE * 2);
      default: hystX = EXT_W'(HYST_BASE * 4);
    endcase
  end

  assign tempX       = EXT_W'(sampleTemp);
  assign lowerX      = EXT_W'(lowerLim);
  assign highLimX[0] = EXT_W'(upperLim);
  assign highLimX[1] = EXT_W'(critLim);

  // Upper and critical limits share one high-side comparator shape (R2, R4)
  for (genvar gh = 0; gh < 2; gh++) begin : g_high
    assign highSet[gh] = tempX > highLimX[gh];
    assign highClr[gh] = tempX <= (highLimX[gh] - hystX);
  end

  always_comb begin
    strobes.hiSet = highSet[0];
    strobes.hiClr = highClr[0];
    strobes.crSet = highSet[1];
    strobes.crClr = highClr[1];
    // Low side: hysteresis added to the bound (R3)
    strobes.loSet = tempX < lowerX;
    strobes.loClr = tempX >= (lowerX + hystX);
  end

endmodule

// File: rtl/therm_event_ctrl.sv
module therm_event_ctrl
  import therm_event_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleValid,
  input  logic       clearPulse,
  input  evCfg_t     cfg,
  input  cmpStrobe_t strobes,
  output logic       aboveHigh,
  output logic       belowLow,
  output logic       aboveCrit,
  output logic       eventN
);

  logic irqLatch;
  logic freshRise;
  logic eventAct;

  // A latch needs a 0->1 flag transition on this sample (R7)
  assign freshRise = sampleValid &&
                     ((cfg.windowEn && strobes.hiSet && !aboveHigh) ||
                      (cfg.windowEn && strobes.loSet && !belowLow)  ||
                      (strobes.crSet && !aboveCrit));

  // Flags move only on a sample strobe (R5)
  always_ff @(posedge clk) begin
    if (!rstN) begin
      aboveHigh <= 1'b0;
      belowLow  <= 1'b0;
      aboveCrit <= 1'b0;
    end else if (sampleValid) begin
      if (strobes.hiSet)      aboveHigh <= 1'b1;
      else if (strobes.hiClr) aboveHigh <= 1'b0;
      if (strobes.loSet)      belowLow  <= 1'b1;
      else if (strobes.loClr) belowLow  <= 1'b0;
      if (strobes.crSet)      aboveCrit <= 1'b1;
      else if (strobes.crClr) aboveCrit <= 1'b0;
    end
  end

  // Latched alarm: a fresh crossing wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN)
      irqLatch <= 1'b0;
    else if (cfg.mode != EV_MODE_LATCH)
      irqLatch <= 1'b0;
    else if (freshRise)
      irqLatch <= 1'b1;
    else if (clearPulse)
      irqLatch <= 1'b0;
  end

  // The critical flag drives the output as a comparator in every mode (R8)
  always_comb begin
    unique case (cfg.mode)
      EV_MODE_LATCH: eventAct = irqLatch || aboveCrit;
      EV_MODE_CRIT:  eventAct = aboveCrit;
      default:       eventAct = (cfg.windowEn && (aboveHigh || belowLow)) || aboveCrit;
    endcase
  end

  // Active low; the enable bit masks the output only, not the flags (R10)
  assign eventN = !(cfg.eventEn && eventAct);

endmodule

// File: rtl/therm_event_top.sv
module therm_event_top
  import therm_event_pkg::*;
#(
  parameter int TEMP_W    = 13,
  parameter int FRAC_BITS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic [TEMP_W-1:0] sampleTemp,
  input  logic              limWrEn,
  input  logic [1:0]        limSel,
  input  logic [TEMP_W-1:0] limWrData,
  input  logic              cfgWrEn,
  input  logic [5:0]        cfgWrData,
  input  logic              clearPulse,
  output logic              eventN,
  output logic              aboveHigh,
  output logic              belowLow,
  output logic              aboveCrit
);

  evCfg_t                   cfgQ;
  cmpStrobe_t               cmpStb;
  logic signed [TEMP_W-1:0] lowerQ;
  logic signed [TEMP_W-1:0] upperQ;
  logic signed [TEMP_W-1:0] critQ;

  therm_event_regs #(.TEMP_W(TEMP_W)) u_regs (
    .clk       (clk),
    .rstN      (rstN),
    .limWrEn   (limWrEn),
    .limSel    (limSel),
    .limWrData (limWrData),
    .cfgWrEn   (cfgWrEn),
    .cfgWrData (cfgWrData),
    .cfg       (cfgQ),
    .lowerLim  (lowerQ),
    .upperLim  (upperQ),
    .critLim   (critQ)
  );

  therm_event_datapath #(.TEMP_W(TEMP_W), .FRAC_BITS(FRAC_BITS)) u_dp (
    .sampleTemp ($signed(sampleTemp)),
    .lowerLim   (lowerQ),
    .upperLim   (upperQ),
    .critLim    (critQ),
    .hystCode   (cfgQ.hyst),
    .strobes    (cmpStb)
  );

  therm_event_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .sampleValid (sampleValid),
    .clearPulse  (clearPulse),
    .cfg         (cfgQ),
    .strobes     (cmpStb),
    .aboveHigh   (aboveHigh),
    .belowLow    (belowLow),
    .aboveCrit   (aboveCrit),
    .eventN      (eventN)
  );

endmodule

// File: rtl/therm_event_chk.sv
module therm_event_chk #(
  parameter int TEMP_W = 13
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     sampleValid,
  input logic [TEMP_W-1:0]        sampleTemp,
  input logic                     cfgWrEn,
  input logic                     clearPulse,
  input logic signed [TEMP_W-1:0] upperLim,
  input logic signed [TEMP_W-1:0] lowerLim,
  input logic                     eventEn,
  input logic                     windowEn,
  input logic [1:0]               mode,
  input logic                     aboveHigh,
  input logic                     belowLow,
  input logic                     aboveCrit,
  input logic                     eventN
);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> $stable({aboveHigh, belowLow, aboveCrit}));

  p_high_set_r2: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && ($signed(sampleTemp) > upperLim)) |=> aboveHigh);

  p_low_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && ($signed(sampleTemp) < lowerLim)) |=> belowLow);

  p_mask_r10: assert property (@(posedge clk) disable iff (!rstN)
    !eventEn |-> eventN);

  p_crit_forces_r8: assert property (@(posedge clk) disable iff (!rstN)
    (eventEn && aboveCrit) |-> !eventN);

  p_crit_only_r9: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd2 && !aboveCrit) |-> eventN);

  p_cmp_window_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((mode == 2'd1 || mode == 2'd3) && eventEn && windowEn && (aboveHigh || belowLow)) |-> !eventN);

  p_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd0 && clearPulse && !sampleValid && !cfgWrEn && !aboveCrit) |=> eventN);

endmodule

bind therm_event_top therm_event_chk #(.TEMP_W(TEMP_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .sampleValid (sampleValid),
  .sampleTemp  (sampleTemp),
  .cfgWrEn     (cfgWrEn),
  .clearPulse  (clearPulse),
  .upperLim    (upperQ),
  .lowerLim    (lowerQ),
  .eventEn     (cfgQ.eventEn),
  .windowEn    (cfgQ.windowEn),
  .mode        (cfgQ.mode),
  .aboveHigh   (aboveHigh),
  .belowLow    (belowLow),
  .aboveCrit   (aboveCrit),
  .eventN      (eventN)
);

// File: tb/therm_event_top_tb.sv
`timescale 1ns/1ps
module therm_event_top_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic        sampleValid;
  logic [12:0] sampleTemp;
  logic        limWrEn;
  logic [1:0]  limSel;
  logic [12:0] limWrData;
  logic        cfgWrEn;
  logic [5:0]  cfgWrData;
  logic        clearPulse;
  logic        eventN, aboveHigh, belowLow, aboveCrit;

  int nTests = 0;
  int nFail  = 0;
  bit done   = 1'b0;

  // Reference model state
  int mLo, mHi, mCr, mMode, mHyst;
  bit mEn, mWin, fHi, fLo, fCr, fIrq;

  always #4 clk = ~clk;

  therm_event_top u_dut (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleTemp(sampleTemp),
    .limWrEn(limWrEn), .limSel(limSel), .limWrData(limWrData),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData), .clearPulse(clearPulse),
    .eventN(eventN), .aboveHigh(aboveHigh), .belowLow(belowLow), .aboveCrit(aboveCrit)
  );

  function automatic int hystOf(int code);
    case (code)
      0: return 0;
      1: return 24;
      2: return 48;
      default: return 96;
    endcase
  endfunction

  function automatic bit expEventN();
    bit act;
    if (mMode == 0)      act = fIrq || fCr;
    else if (mMode == 2) act = fCr;
    else                 act = (mWin && (fHi || fLo)) || fCr;
    return !(mEn && act);
  endfunction

  task automatic chk(string tag);
    logic [3:0] act, exp;
    act = {eventN, aboveHigh, belowLow, aboveCrit};
    exp = {expEventN(), fHi, fLo, fCr};
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: {eventN,hi,lo,crit} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // One clock with the given stimulus; model advanced at the edge, outputs checked after it
  task automatic cyc(string tag, bit sv, int t, bit lw = 0, int lsel = 0, int ldata = 0,
                     bit cw = 0, int cdata = 0, bit clr = 0);
    int h;
    bit nHi, nLo, nCr, nIrq, rise;
    sampleValid = sv;  sampleTemp = t[12:0];
    limWrEn = lw;      limSel = lsel[1:0];  limWrData = ldata[12:0];
    cfgWrEn = cw;      cfgWrData = cdata[5:0];
    clearPulse = clr;
    h = hystOf(mHyst);
    nHi = fHi; nLo = fLo; nCr = fCr;
    if (sv) begin
      if (t > mHi) nHi = 1; else if (t <= mHi - h) nHi = 0;
      if (t < mLo) nLo = 1; else if (t >= mLo + h) nLo = 0;
      if (t > mCr) nCr = 1; else if (t <= mCr - h) nCr = 0;
    end
    rise = sv && ((mWin && nHi && !fHi) || (mWin && nLo && !fLo) || (nCr && !fCr));
    if (mMode != 0) nIrq = 0;
    else if (rise)  nIrq = 1;
    else if (clr)   nIrq = 0;
    else            nIrq = fIrq;
    @(posedge clk);
    #1;
    fHi = nHi; fLo = nLo; fCr = nCr; fIrq = nIrq;
    if (lw) begin
      if (lsel == 0) mLo = ldata;
      else if (lsel == 1) mHi = ldata;
      else if (lsel == 2) mCr = ldata;
    end
    if (cw) begin
      mEn = cdata[0]; mWin = cdata[1]; mMode = (cdata >> 2) & 3; mHyst = (cdata >> 4) & 3;
    end
    chk(tag);
    @(negedge clk);
    sampleValid = 0; limWrEn = 0; cfgWrEn = 0; clearPulse = 0;
  endtask

  function automatic int cfgWord(bit en, bit win, int mode, int hy);
    return (hy << 4) | (mode << 2) | (int'(win) << 1) | int'(en);
  endfunction

  task automatic setLimit(int sel, int val);
    cyc("R11 limit write", 0, 0, 1, sel, val);
  endtask

  task automatic setCfg(bit en, bit win, int mode, int hy);
    cyc("R11 config write", 0, 0, 0, 0, 0, 1, cfgWord(en, win, mode, hy));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      nTests++; nFail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'h5EED1234));
    rstN = 0; sampleValid = 0; sampleTemp = '0; limWrEn = 0; limSel = '0;
    limWrData = '0; cfgWrEn = 0; cfgWrData = '0; clearPulse = 0;
    mLo = -4096; mHi = 4095; mCr = 4095; mMode = 0; mHyst = 0;
    mEn = 0; mWin = 0; fHi = 0; fLo = 0; fCr = 0; fIrq = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    #1 chk("R1 reset state");
    // R1: reset limits admit the extreme readings without any flag
    cyc("R1 reset limits", 1, 4095);
    cyc("R1 reset limits", 1, -4096);

    setLimit(0, 0); setLimit(1, 1280); setLimit(2, 1440);
    setCfg(1, 1, 1, 1);
    cyc("R6 inside window", 1, 400);
    cyc("R2 R6 above upper", 1, 1281);
    cyc("R5 no strobe holds", 0, 0);
    cyc("R2 inside hysteresis holds", 1, 1270);
    cyc("R2 clear at upper-H", 1, 1256);
    cyc("R3 negative below lower", 1, -1);
    cyc("R3 inside hysteresis holds", 1, 23);
    cyc("R3 clear at lower+H", 1, 24);
    cyc("R6 clear ignored", 1, 1300, 0, 0, 0, 0, 0, 1);
    setCfg(1, 0, 1, 1);
    cyc("R12 window off, low flag only", 1, -5);
    cyc("R12 window off, high flag only", 1, 1300);
    cyc("R11 select 3 ignored", 0, 0, 1, 3, -2000);
    cyc("R11 select 3 ignored", 1, 400);
    setCfg(1, 1, 2, 1);
    cyc("R4 R9 critical set", 1, 1441);
    cyc("R4 R9 critical clear at crit-H", 1, 1416);
    cyc("R9 upper only no event", 1, 1300);
    setCfg(1, 1, 0, 1);
    cyc("R7 settle", 1, 400);
    cyc("R7 latch on rise", 1, 1300);
    cyc("R7 clear while present", 0, 0, 0, 0, 0, 0, 0, 1);
    cyc("R7 no refire", 1, 1310);
    cyc("R7 drop", 1, 1000);
    cyc("R7 fresh refire", 1, 1300);
    cyc("R7 clear", 0, 0, 0, 0, 0, 0, 0, 1);
    cyc("R8 critical in latched mode", 1, 1500);
    cyc("R8 clear has no effect", 0, 0, 0, 0, 0, 0, 0, 1);
    cyc("R8 critical released", 1, 400);
    setCfg(0, 1, 1, 2);
    cyc("R10 masked, flags update", 1, 1500);
    cyc("R10 masked low", 1, -300);
    setCfg(1, 1, 3, 3);
    cyc("R6 mode 3 comparator", 1, -300);

    // Constrained random: limits near each other, readings near the limits
    for (int i = 0; i < 600; i++) begin
      int k, base, t;
      k = $urandom_range(0, 19);
      if (k == 0) begin
        int lo;
        lo = $urandom_range(0, 800) - 400;
        setLimit(0, lo);
        setLimit(1, lo + $urandom_range(50, 600));
        setLimit(2, lo + $urandom_range(300, 1200));
      end else if (k == 1) begin
        setCfg(($urandom_range(0, 7) != 0), $urandom_range(0, 1), $urandom_range(0, 3),
               $urandom_range(0, 3));
      end else begin
        int c;
        c = $urandom_range(0, 2);
        base = (c == 0) ? mLo : ((c == 1) ? mHi : mCr);
        t = base + $urandom_range(0, 240) - 120;
        if (t > 4095) t = 4095;
        if (t < -4096) t = -4096;
        cyc("R2 R3 R4 R6 R7 R9 random", $urandom_range(0, 3) != 0, t, 0, 0, 0, 0, 0,
            $urandom_range(0, 5) == 0);
      end
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule